// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Timing

This block is a synchronous serial master. On a start request it asserts one active-low chip select, waits a programmable setup time, runs one frame of 4 to 16 bits over a serial clock while shifting data out on the output line and in from the input line, waits a programmable hold time, releases the chip select and reports the received word with a one-cycle done pulse.

Each transfer carries its own attribute set, sampled when the start is accepted:
- idle clock level
- clock phase
- bit order
- frame length
- the setup and hold delays

Each delay is an odd prescaler (1, 3, 5 or 7) times a power-of-two scaler. The serial clock half-period is a fixed parameter of at least two system clocks. There is no slave mode, no queueing and only one chip select.

Top module: `spi_cs_master`

## Requirements
- R1: With the engine idle, `sck_o` follows `cpol_i` one cycle later (0 means a low idle clock, 1 means a high idle clock). The value sampled at start is the one used for the whole transfer. A change of `cpol_i` while busy has no effect on the frame, and `sck_o` is back at the sampled level when `done_o` pulses.
- R2: With `cpha_i`=0, the engine captures `miso_i` on each leading clock edge and changes `mosi_o` on the trailing edges. The first bit is on `mosi_o` from the cycle in which `cs_n_o` falls.
- R3: With `cpha_i`=1, `mosi_o` changes on each leading clock edge and `miso_i` is captured on each trailing edge.
- R4: Bit order applies to both directions.
  - With `lsb_first_i`=0, bit N-1 is sent first and the first received bit lands in bit N-1 of `rx_data_o`.
  - With `lsb_first_i`=1, bit 0 is sent first and the first received bit lands in bit 0.
  - Bits of `rx_data_o` at and above N read 0.
- R5: `frame_bits_i` holds N-1, so the code 3 gives 4 bits and the code 15 gives 16 bits. Codes 0, 1 and 2 give 4 bits. A frame has exactly 2N clock edges.
- R6: The first clock edge comes exactly (2·p+1)·2^(s+1) system cycles after `cs_n_o` falls, where p is `setup_pre_i` (00→1, 01→3, 10→5, 11→7) and s is `setup_scl_i`.
- R7: `cs_n_o` rises exactly (2·p+1)·2^(s+1) cycles after the last clock edge, with p from `hold_pre_i` and s from `hold_scl_i`.
- R8: Consecutive clock edges are exactly HALF_DIV system cycles apart. The clock toggles only while `cs_n_o` is low.
- R9: `done_o` is high for exactly one cycle, one cycle after `cs_n_o` rises, and `rx_data_o` then holds the received word.
- R10: A start while `busy_o` is high is ignored, and so are attribute or data changes during a transfer. `busy_o` is high whenever `cs_n_o` is low.
- R11: After reset, `cs_n_o` is high, `sck_o`, `done_o` and `busy_o` are low, and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| tx_data_i | input | FRAME_W | Word to send, right-aligned |
| frame_bits_i | input | LEN_W | Frame length minus one |
| cpol_i | input | 1 | Idle clock level |
| cpha_i | input | 1 | Clock phase |
| lsb_first_i | input | 1 | 1: least significant bit first |
| setup_pre_i | input | 2 | Setup delay prescaler code |
| setup_scl_i | input | SCL_W | Setup delay scaler |
| hold_pre_i | input | 2 | Hold delay prescaler code |
| hold_scl_i | input | SCL_W | Hold delay scaler |
| miso_i | input | 1 | Serial data in |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | FRAME_W | Received word |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
All results are timed against the cycle in which `cs_n_o` falls, which is one clock after the start request is sampled:
- The first serial clock edge is due exactly one setup delay later.
- Each further edge is due HALF_DIV cycles after the previous one.
- The chip-select release is due one hold delay after the last edge.
- `done_o` and the received word are due one cycle after that.

The bench samples every output on the falling system clock edge. It counts those samples from the chip-select fall and compares each event's cycle number with the count computed from the attributes. The peripheral model drives `miso_i` and samples `mosi_o` at those same sample points, only on the edge type the phase setting assigns it.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_TRAIL = 3'd3,
    ST_DONE  = 3'd4
  } spi_state_e;
endpackage

// File: rtl/spi_cs_delay.sv
// Converts a prescaler code and a scaler into a cycle count minus one.
module spi_cs_delay #(
  parameter int SCL_W = 4,
  parameter int DLY_W = 20
) (
  input  logic [1:0]       pre_i,
  input  logic [SCL_W-1:0] scl_i,
  output logic [DLY_W-1:0] cyc_m1_o
);
  logic [DLY_W-1:0] odd_mult;
  logic [SCL_W:0]   shamt;

  always_comb begin
    odd_mult = DLY_W'({pre_i, 1'b1});
    shamt    = {1'b0, scl_i} + {{SCL_W{1'b0}}, 1'b1};
    cyc_m1_o = (odd_mult << shamt) - DLY_W'(1);
  end
endmodule

// File: rtl/spi_cs_timer.sv
// Loadable down-counter shared by setup, half-period and hold phases.
module spi_cs_timer #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)          cnt_d = val_i;
    else if (cnt_q != 0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_shifter.sv
// Holds the outgoing and incoming words and a bit index mapped by bit order.
module spi_cs_shifter #(
  parameter int FRAME_W = 16,
  parameter int LEN_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               lsb_i,
  input  logic [LEN_W-1:0]   last_i,
  input  logic               adv_i,
  input  logic               cap_i,
  input  logic               miso_i,
  output logic               mosi_o,
  output logic [FRAME_W-1:0] rx_o
);
  logic [FRAME_W-1:0] tx_q, rx_q, rx_d;
  logic [LEN_W-1:0]   idx_q, idx_d, last_q, pos;
  logic               lsb_q;

  assign pos    = lsb_q ? idx_q : (last_q - idx_q);
  assign mosi_o = tx_q[pos];
  assign rx_o   = rx_q;

  always_comb begin
    rx_d  = rx_q;
    idx_d = idx_q;
    if (load_i) begin
      rx_d  = '0;
      idx_d = '0;
    end else begin
      if (cap_i) rx_d[pos] = miso_i;
      if (adv_i) idx_d = idx_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      lsb_q  <= 1'b0;
      last_q <= '0;
      rx_q   <= '0;
      idx_q  <= '0;
    end else begin
      if (load_i) begin
        tx_q   <= tx_i;
        lsb_q  <= lsb_i;
        last_q <= last_i;
      end
      rx_q  <= rx_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int FRAME_W  = 16,
  parameter int SCL_W    = 4,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(FRAME_W),
  localparam int DLY_W   = 4 + (1 << SCL_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  input  logic [LEN_W-1:0]   frame_bits_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               lsb_first_i,
  input  logic [1:0]         setup_pre_i,
  input  logic [SCL_W-1:0]   setup_scl_i,
  input  logic [1:0]         hold_pre_i,
  input  logic [SCL_W-1:0]   hold_scl_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_data_o,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               cs_n_o
);
  import spi_cs_pkg::*;

  localparam logic [DLY_W-1:0] HALF_M1 = DLY_W'(HALF_DIV - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  spi_state_e         state_q, state_d;
  logic               cs_q, cs_d, sck_q, sck_d, done_q, done_d;
  logic [LEN_W:0]     edge_q, edge_d, last_edge;
  logic [FRAME_W-1:0] rx_out_q, rx_out_d, shf_rx;
  logic               cpol_q, cpha_q;
  logic [LEN_W-1:0]   nbits_q, nbits_sel;
  logic [DLY_W-1:0]   hold_m1_q, hold_m1, setup_m1, tmr_val;
  logic               tmr_load, tmr_zero, go, is_edge, change, adv, cap;

  spi_cs_delay #(.SCL_W(SCL_W), .DLY_W(DLY_W)) i_setup_dly (
    .pre_i(setup_pre_i), .scl_i(setup_scl_i), .cyc_m1_o(setup_m1));
  spi_cs_delay #(.SCL_W(SCL_W), .DLY_W(DLY_W)) i_hold_dly (
    .pre_i(hold_pre_i), .scl_i(hold_scl_i), .cyc_m1_o(hold_m1));

  spi_cs_timer #(.W(DLY_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero));

  assign nbits_sel = (frame_bits_i < LEN_W'(3)) ? LEN_W'(3) : frame_bits_i;
  assign go        = (state_q == ST_IDLE) && start_i;
  assign last_edge = {nbits_q, 1'b1};
  assign is_edge   = tmr_zero && ((state_q == ST_LEAD) || (state_q == ST_SHIFT));
  assign change    = edge_q[0] ^ cpha_q;
  assign adv       = is_edge && change && (edge_q != '0) && (edge_q != last_edge);
  assign cap       = is_edge && !change;

  spi_cs_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) i_shifter (
    .clk_i(clk_i), .rst_ni(rst_n), .load_i(go), .tx_i(tx_data_i),
    .lsb_i(lsb_first_i), .last_i(nbits_sel), .adv_i(adv), .cap_i(cap),
    .miso_i(miso_i), .mosi_o(mosi_o), .rx_o(shf_rx));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    sck_d    = sck_q;
    edge_d   = edge_q;
    done_d   = 1'b0;
    rx_out_d = rx_out_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        sck_d = cpol_i;
        if (start_i) begin
          state_d  = ST_LEAD;
          cs_d     = 1'b0;
          edge_d   = '0;
          tmr_load = 1'b1;
          tmr_val  = setup_m1;
        end
      end
      ST_LEAD, ST_SHIFT: begin
        if (tmr_zero) begin
          sck_d    = ~sck_q;
          edge_d   = edge_q + (LEN_W+1)'(1);
          tmr_load = 1'b1;
          if (edge_q == last_edge) begin
            tmr_val = hold_m1_q;
            state_d = ST_TRAIL;
          end else begin
            tmr_val = HALF_M1;
            state_d = ST_SHIFT;
          end
        end
      end
      ST_TRAIL: begin
        if (tmr_zero) begin
          cs_d    = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        done_d   = 1'b1;
        rx_out_d = shf_rx;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      edge_q    <= '0;
      done_q    <= 1'b0;
      rx_out_q  <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      nbits_q   <= '0;
      hold_m1_q <= '0;
    end else begin
      state_q  <= state_d;
      cs_q     <= cs_d;
      sck_q    <= sck_d;
      edge_q   <= edge_d;
      done_q   <= done_d;
      rx_out_q <= rx_out_d;
      if (go) begin
        cpol_q    <= cpol_i;
        cpha_q    <= cpha_i;
        nbits_q   <= nbits_sel;
        hold_m1_q <= hold_m1;
      end
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rx_data_o = rx_out_q;
  assign sck_o     = sck_q;
  assign cs_n_o    = cs_q;
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic busy_o,
  input logic done_o,
  input logic sck_o,
  input logic cs_n_o
);
  logic [1:0] age_q;
  logic       settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign settled = (age_q == 2'd3);

  assert_idle_level_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && !busy_o && $past(!busy_o)) |-> (sck_o == $past(cpol_i)));

  assert_setup_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |=> $stable(sck_o));

  assert_hold_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> $stable(sck_o));

  assert_sck_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && busy_o && $past(busy_o) && (sck_o != $past(sck_o)))
      |-> (!cs_n_o && !$past(cs_n_o)));

  assert_done_after_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_cover_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> busy_o);
endmodule

bind spi_cs_master spi_cs_master_chk i_spi_cs_master_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol_i), .busy_o(busy_o),
  .done_o(done_o), .sck_o(sck_o), .cs_n_o(cs_n_o));

// File: tb/test_spi_cs_master.sv
`timescale 1ns/1ps
module test_spi_cs_master;
  localparam int HALF = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i, cpol_i, cpha_i, lsb_first_i, miso_i;
  logic [15:0] tx_data_i;
  logic [3:0]  frame_bits_i;
  logic [1:0]  setup_pre_i, hold_pre_i;
  logic [3:0]  setup_scl_i, hold_scl_i;
  logic        busy_o, done_o, sck_o, mosi_o, cs_n_o;
  logic [15:0] rx_data_o;

  int nchecks = 0;
  int nfail   = 0;
  int ncyc    = 0;

  always #2.5 clk_i = ~clk_i;

  spi_cs_master #(.FRAME_W(16), .SCL_W(4), .HALF_DIV(HALF)) i_spi_cs_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tx_data_i(tx_data_i),
    .frame_bits_i(frame_bits_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .lsb_first_i(lsb_first_i), .setup_pre_i(setup_pre_i),
    .setup_scl_i(setup_scl_i), .hold_pre_i(hold_pre_i), .hold_scl_i(hold_scl_i),
    .miso_i(miso_i), .busy_o(busy_o), .done_o(done_o), .rx_data_o(rx_data_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o));

  always @(posedge clk_i) begin
    ncyc <= ncyc + 1;
    if (ncyc > 150000) begin
      nchecks = nchecks + 1;
      nfail   = nfail + 1;
      $display("FAIL watchdog expired act=%0d exp<=150000", ncyc);
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int bpos(input int i, input int n, input logic lsb);
    return lsb ? i : n - 1 - i;
  endfunction

  function automatic int dly(input logic [1:0] p, input logic [3:0] s);
    return (2 * int'(p) + 1) << (int'(s) + 1);
  endfunction

  task automatic run_xfer(input logic [15:0] tx, input logic [15:0] srx,
                          input logic [3:0] fb, input logic pol, input logic pha,
                          input logic lsb, input logic [1:0] sp, input logic [3:0] ss,
                          input logic [1:0] hp, input logic [3:0] hs, input bit perturb);
    int n, dsu, dho, cyc, edges, last_e, rise_c, done_c, k;
    logic [15:0] mask, got_mosi, got_rx;
    logic prev_sck, lead;
    bit gap_bad;
    n    = (fb < 3) ? 4 : int'(fb) + 1;
    mask = (n == 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    dsu  = dly(sp, ss);
    dho  = dly(hp, hs);
    @(negedge clk_i);
    tx_data_i = tx; frame_bits_i = fb; cpol_i = pol; cpha_i = pha; lsb_first_i = lsb;
    setup_pre_i = sp; setup_scl_i = ss; hold_pre_i = hp; hold_scl_i = hs;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(cs_n_o == 1'b0, "R6 cs low after start", int'(cs_n_o), 0);
    cyc = 0; edges = 0; last_e = 0; rise_c = -1; done_c = -1;
    got_mosi = '0; got_rx = '0; gap_bad = 0; prev_sck = pol;
    if (!pha) miso_i = srx[bpos(0, n, lsb)];
    while (1) begin
      if (cyc > 4000) begin
        chk(1'b0, "R9 no done", cyc, 0);
        break;
      end
      if (perturb && cyc == 2) begin
        cpol_i = ~pol; cpha_i = ~pha; lsb_first_i = ~lsb; tx_data_i = ~tx;
        frame_bits_i = 4'd15; setup_pre_i = ~sp; hold_pre_i = ~hp; start_i = 1'b1;
      end
      if (perturb && cyc == 3) start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
      if (sck_o !== prev_sck) begin
        lead = (prev_sck == pol);
        if (edges == 0) chk(cyc == dsu, "R6 setup delay", cyc, dsu);
        else if (cyc - last_e != HALF) gap_bad = 1;
        last_e = cyc;
        if (lead ^ pha) begin
          if (edges / 2 < n) got_mosi[bpos(edges / 2, n, lsb)] = mosi_o;
        end else begin
          k = pha ? edges / 2 : edges / 2 + 1;
          if (k < n) miso_i = srx[bpos(k, n, lsb)];
        end
        edges++;
        prev_sck = sck_o;
      end
      if (cs_n_o && rise_c < 0) rise_c = cyc;
      if (done_o) begin
        done_c = cyc;
        got_rx = rx_data_o;
        break;
      end
    end
    chk(edges == 2 * n, "R5 edge count", edges, 2 * n);
    chk(!gap_bad, "R8 half period", int'(gap_bad), 0);
    chk(rise_c - last_e == dho, "R7 hold delay", rise_c - last_e, dho);
    chk(done_c - rise_c == 1, "R9 done timing", done_c - rise_c, 1);
    chk(got_rx == (srx & mask), pha ? "R3 rx word (R4 order)" : "R2 rx word (R4 order)",
        int'(got_rx), int'(srx & mask));
    chk(got_mosi == (tx & mask), "R4 mosi word", int'(got_mosi), int'(tx & mask));
    chk(sck_o == pol, "R1 sck level at done", int'(sck_o), int'(pol));
    if (perturb) begin
      cpol_i = pol;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk_i);
        if (!cs_n_o || done_o) begin
          chk(1'b0, "R10 ignored start ran a frame", int'(done_o), 0);
          break;
        end
      end
      chk(cs_n_o && !busy_o, "R10 idle after ignored start", int'(busy_o), 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; cpol_i = 1'b0; cpha_i = 1'b0; lsb_first_i = 1'b0;
    miso_i = 1'b0; tx_data_i = '0; frame_bits_i = 4'd7; setup_pre_i = '0;
    setup_scl_i = '0; hold_pre_i = '0; hold_scl_i = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R11 reset state
    chk(cs_n_o && !sck_o && !done_o && !busy_o, "R11 reset outputs",
        int'({cs_n_o, sck_o, done_o, busy_o}), 8);
    chk(rx_data_o == 16'h0, "R11 reset rx", int'(rx_data_o), 0);
    // R1 idle level follows cpol_i
    cpol_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b1 && cs_n_o, "R1 idle high", int'(sck_o), 1);
    cpol_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(sck_o == 1'b0, "R1 idle low", int'(sck_o), 0);
    // directed corners: all four modes, both orders, length clamp, long delays
    run_xfer(16'hA5C3, 16'h3C5A, 4'd7,  0, 0, 0, 2'd0, 4'd0, 2'd0, 4'd0, 0);
    run_xfer(16'hA5C3, 16'h3C5A, 4'd7,  1, 1, 1, 2'd1, 4'd0, 2'd2, 4'd1, 0);
    run_xfer(16'h1234, 16'hBEEF, 4'd15, 0, 1, 0, 2'd3, 4'd2, 2'd3, 4'd3, 0);
    run_xfer(16'hFFF6, 16'h0009, 4'd0,  1, 0, 1, 2'd0, 4'd1, 2'd1, 4'd0, 0);
    run_xfer(16'h000B, 16'hFFF4, 4'd3,  0, 0, 1, 2'd2, 4'd4, 2'd0, 4'd0, 0);
    // R10 start and attributes changed while busy
    run_xfer(16'h5A5A, 16'hC3C3, 4'd11, 0, 0, 0, 2'd1, 4'd1, 2'd1, 4'd1, 1);
    run_xfer(16'h6789, 16'h1357, 4'd9,  1, 1, 1, 2'd0, 4'd0, 2'd0, 4'd0, 1);
    for (int t = 0; t < 40; t++) begin
      run_xfer(16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom_range(0, 3)),
               2'($urandom), 4'($urandom_range(0, 3)), (t % 8) == 3);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule